// File: doc/BRIEF.md
# Protected-Window Read-After-Write Interlock

This block sits between the memory stages of a pipelined processor and its data bus. It keeps reads and writes that target one protected address window in program order. Any read that falls in the window is held back while a write that also falls in the window is still waiting to go out to the bus. Addresses do not have to match. Every access inside the window counts as the same resource, because side effects in that region, such as peripheral registers that clear each other, can link locations that differ.

The window is an aligned power-of-two block of a 22-bit word address space. Software registers supply a 16-bit base, a 16-bit size mask and an enable. The block samples them into its own configuration register on every clock edge. Up to two writes that the pipeline has accepted but not yet issued are held in a small in-order tracker. Each tracker entry stores whether that write fell in the window when it was accepted. The read stall is combinational from the tracker, the sampled configuration and the read request.

Top module: `prw_interlock`

## Requirements
- R1: While reset is high, the tracked writes and the sampled configuration are cleared. In the first cycle after reset the stall is low whatever the configuration inputs hold, and the interlock stays off until the enable has been sampled high at a clock edge.
- R2: While the sampled enable is 0, `rd_stall_o` stays 0 whatever the addresses and pending writes are.
- R3: When the sampled enable is 1, a requested read inside the window is stalled while any tracked write carries an in-window flag. During the stall `rd_grant_o` is 0.
- R4: A read outside the window is never stalled, even while in-window writes are pending.
- R5: Inside the window no address match is needed. A read at one in-window address stalls behind a write to a different in-window address.
- R6: The window mask is `{cfg_size_i, 6'b111111}` and the window base is `cfg_base_i << 6`. An address is in the window when `(addr & ~mask) == (base & ~mask)`. A size value of 0x0000 gives 64 words, 0x0001 gives 128 words, 0x003F gives 4K words and 0xFFFF gives the full 4M words.
- R7: A write and a read on the bus in the same cycle count as write first. In the cycle where the last in-window write is issued, an in-window read is still stalled. In the next cycle it is free.
- R8: Writes outside the window are tracked but never cause a stall.
- R9: Configuration inputs take effect one cycle after they are presented. A write's in-window flag is fixed when the write is accepted.
- R10: Up to two writes are tracked and are issued oldest first. Each `wr_issue_i` retires the oldest entry. An accept and an issue in the same cycle both take effect.
- R11: `rd_grant_o` is 1 exactly when `rd_req_i` is 1 and `rd_stall_o` is 0. With no request, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_i | input | 16 | Window base in 64-word units |
| cfg_size_i | input | 16 | Window size mask, ones in offset positions above bit 5 |
| cfg_en_i | input | 1 | Interlock enable |
| wr_accept_i | input | 1 | A write enters the tracker this cycle |
| wr_accept_addr_i | input | 22 | Word address of the accepted write |
| wr_issue_i | input | 1 | The oldest tracked write goes to the bus this cycle |
| rd_req_i | input | 1 | A read wants the bus this cycle |
| rd_addr_i | input | 22 | Word address of the read |
| rd_stall_o | output | 1 | Read is held back |
| rd_grant_o | output | 1 | Read may proceed |

## Verification
The stall and grant depend combinationally on the read inputs in the same cycle. Changes to configuration, accepts and issues reach them one clock edge later. The bench therefore drives every input just after a falling edge and checks the outputs one nanosecond later, before the next rising edge. Where a result belongs to the following cycle, such as the release after the last issue or a new enable value, the check is made only after one more falling edge. The same-cycle checks confirm that the write-first stall is still present while the issue is on the bus.

// File: rtl/prw_pkg.sv
package prw_pkg;

    // Word address width and the width of the configuration fields.
    localparam int ADDR_W    = 22;
    localparam int CFG_W     = 16;
    // Low address bits that lie below the smallest window granule.
    localparam int GRAN_W    = ADDR_W - CFG_W;
    // Number of writes that may wait between acceptance and issue.
    localparam int TRK_DEPTH = 2;

    typedef struct packed {
        logic [CFG_W-1:0] base;
        logic [CFG_W-1:0] size;
        logic             en;
    } prw_cfg_t;

    typedef struct packed {
        logic vld;
        logic inwin;
    } prw_slot_t;

    function automatic logic [ADDR_W-1:0] full_mask(input logic [CFG_W-1:0] sz);
        return {sz, {GRAN_W{1'b1}}};
    endfunction

    function automatic logic [ADDR_W-1:0] full_base(input logic [CFG_W-1:0] b);
        return {b, {GRAN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/prw_cfg_reg.sv
module prw_cfg_reg
    import prw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  prw_cfg_t cfg_d,
    output prw_cfg_t cfg_q
);

    // Software values are resampled on every edge; reset leaves the interlock off.
    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

endmodule

// File: rtl/prw_window_match.sv
module prw_window_match #(
    parameter int ADDR_W = prw_pkg::ADDR_W,
    parameter int CFG_W  = prw_pkg::CFG_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  base,
    input  logic [CFG_W-1:0]  size_mask,
    output logic              hit
);

    localparam int G = ADDR_W - CFG_W;

    logic [CFG_W-1:0] bit_ok;

    // Offset bits (mask set) are don't-care; the rest must equal the base.
    for (genvar i = 0; i < CFG_W; i++) begin : g_bit
        assign bit_ok[i] = size_mask[i] | (addr[G+i] == base[i]);
    end

    assign hit = &bit_ok;

    // Bits below the smallest granule are always inside any window.
    logic unused_low;
    assign unused_low = ^addr[G-1:0];

endmodule

// File: rtl/prw_wr_tracker.sv
module prw_wr_tracker
    import prw_pkg::*;
#(
    parameter int DEPTH = TRK_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             push_inwin,
    input  logic             pop,
    output logic [DEPTH-1:0] occ,
    output logic             any_inwin
);

    prw_slot_t slot_q  [DEPTH];
    prw_slot_t shifted [DEPTH];
    prw_slot_t slot_d  [DEPTH];

    // Retire the oldest entry first: everything moves one place toward slot 0.
    for (genvar i = 0; i < DEPTH; i++) begin : g_shift
        if (i < DEPTH - 1) begin : g_mid
            assign shifted[i] = pop ? slot_q[i+1] : slot_q[i];
        end else begin : g_top
            assign shifted[i] = pop ? '0 : slot_q[i];
        end
    end

    // Then place a new write in the first free slot after the shift.
    always_comb begin
        logic placed;
        placed = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = shifted[i];
            if (push && !placed && !shifted[i].vld) begin
                slot_d[i].vld   = 1'b1;
                slot_d[i].inwin = push_inwin;
                placed          = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) slot_q[i] <= '0;
            else     slot_q[i] <= slot_d[i];
        end
    end

    logic [DEPTH-1:0] hazard;
    for (genvar i = 0; i < DEPTH; i++) begin : g_flag
        assign occ[i]    = slot_q[i].vld;
        assign hazard[i] = slot_q[i].vld & slot_q[i].inwin;
    end

    assign any_inwin = |hazard;

endmodule

// File: rtl/prw_interlock.sv
module prw_interlock
    import prw_pkg::*;
#(
    parameter int ADDR_W = prw_pkg::ADDR_W,
    parameter int CFG_W  = prw_pkg::CFG_W,
    parameter int DEPTH  = prw_pkg::TRK_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_base_i,
    input  logic [CFG_W-1:0]  cfg_size_i,
    input  logic              cfg_en_i,
    input  logic              wr_accept_i,
    input  logic [ADDR_W-1:0] wr_accept_addr_i,
    input  logic              wr_issue_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_stall_o,
    output logic              rd_grant_o
);

    prw_cfg_t         cfg_d;
    prw_cfg_t         cfg_q;
    logic             rd_in_win;
    logic             wr_in_win;
    logic [DEPTH-1:0] trk_occ;
    logic             trk_hazard;

    assign cfg_d = '{base: cfg_base_i, size: cfg_size_i, en: cfg_en_i};

    prw_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    prw_window_match #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_rd_win (
        .addr      (rd_addr_i),
        .base      (cfg_q.base),
        .size_mask (cfg_q.size),
        .hit       (rd_in_win)
    );

    prw_window_match #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_wr_win (
        .addr      (wr_accept_addr_i),
        .base      (cfg_q.base),
        .size_mask (cfg_q.size),
        .hit       (wr_in_win)
    );

    prw_wr_tracker #(.DEPTH(DEPTH)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .push       (wr_accept_i),
        .push_inwin (wr_in_win),
        .pop        (wr_issue_i),
        .occ        (trk_occ),
        .any_inwin  (trk_hazard)
    );

    // Write-first: an entry issued this cycle still blocks until the edge.
    assign rd_stall_o = cfg_q.en & rd_req_i & rd_in_win & trk_hazard;
    assign rd_grant_o = rd_req_i & ~rd_stall_o;

endmodule

// File: rtl/prw_interlock_chk.sv
module prw_interlock_chk
    import prw_pkg::*;
#(
    parameter int ADDR_W = prw_pkg::ADDR_W,
    parameter int CFG_W  = prw_pkg::CFG_W,
    parameter int DEPTH  = prw_pkg::TRK_DEPTH
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_en_i,
    input logic              rd_req_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic              rd_stall_o,
    input logic              rd_grant_o,
    input prw_cfg_t          cfg_q,
    input logic [DEPTH-1:0]  trk_occ
);

    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] win_base;
    logic              rd_outside;

    assign win_mask   = {cfg_q.size, {(ADDR_W-CFG_W){1'b1}}};
    assign win_base   = {cfg_q.base, {(ADDR_W-CFG_W){1'b0}}};
    assign rd_outside = (rd_addr_i & ~win_mask) != (win_base & ~win_mask);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_stall_o);

    a_r2_disabled_no_stall: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_en_i) |-> !rd_stall_o);

    a_r4_outside_free: assert property (@(posedge clk) disable iff (rst)
        rd_outside |-> !rd_stall_o);

    a_r7_empty_tracker_free: assert property (@(posedge clk) disable iff (rst)
        (trk_occ == '0) |-> !rd_stall_o);

    a_r10_fifo_packed: assert property (@(posedge clk) disable iff (rst)
        ((trk_occ + 1'b1) & trk_occ) == '0);

    a_r11_grant_when_free: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !rd_stall_o) |-> rd_grant_o);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_req_i |-> (!rd_grant_o && !rd_stall_o));

endmodule

bind prw_interlock prw_interlock_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_en_i   (cfg_en_i),
    .rd_req_i   (rd_req_i),
    .rd_addr_i  (rd_addr_i),
    .rd_stall_o (rd_stall_o),
    .rd_grant_o (rd_grant_o),
    .cfg_q      (cfg_q),
    .trk_occ    (trk_occ)
);

// File: tb/prw_interlock_tb_top.sv
module prw_interlock_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg_base_i, cfg_size_i;
    logic        cfg_en_i;
    logic        wr_accept_i, wr_issue_i, rd_req_i;
    logic [21:0] wr_accept_addr_i, rd_addr_i;
    logic        rd_stall_o, rd_grant_o;

    always #4 clk = ~clk;   // 125 MHz

    prw_interlock dut_i (.*);

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct packed {
        logic [15:0] base;
        logic [15:0] size;
        logic        en;
        logic [21:0] wa;
        logic [21:0] ra;
        logic        stall;
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{16'h0010, 16'h0000, 1'b1, 22'h000400, 22'h00043F, 1'b1},
        '{16'h0010, 16'h0000, 1'b1, 22'h000400, 22'h000440, 1'b0},
        '{16'h0010, 16'h0000, 1'b1, 22'h000500, 22'h000410, 1'b0},
        '{16'h0010, 16'h0000, 1'b0, 22'h000400, 22'h000400, 1'b0},
        '{16'h0040, 16'h003F, 1'b1, 22'h001FFF, 22'h001000, 1'b1},
        '{16'h0040, 16'h003F, 1'b1, 22'h001FFF, 22'h002000, 1'b0},
        '{16'h0000, 16'hFFFF, 1'b1, 22'h3FFFFF, 22'h000000, 1'b1},
        '{16'h0002, 16'h0001, 1'b1, 22'h000080, 22'h0000FF, 1'b1},
        '{16'h0002, 16'h0001, 1'b1, 22'h000080, 22'h000100, 1'b0}
    };

    function automatic string vtag(input int i);
        case (i)
            0:       return "R5 R6 64-word";
            1:       return "R4 R6 64-word";
            2:       return "R8";
            3:       return "R2";
            4:       return "R3 R6 4K";
            5:       return "R4 R6 4K";
            6:       return "R3 R6 4M";
            default: return "R6 128-word";
        endcase
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic nxt;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cfg_base_i = 16'h0010; cfg_size_i = 16'h0000; cfg_en_i = 1'b1;
        wr_accept_i = 0; wr_issue_i = 0; rd_req_i = 0;
        wr_accept_addr_i = '0; rd_addr_i = '0;
        repeat (3) nxt();
        rst = 1'b0;

        // R1: configuration still cleared in the first cycle after reset
        rd_req_i = 1; rd_addr_i = 22'h000400;
        #1 chk("R1 stall after reset", rd_stall_o, 1'b0);
        chk("R1 grant after reset", rd_grant_o, 1'b1);
        rd_req_i = 0;
        nxt();

        for (int v = 0; v < 9; v++) begin
            cfg_base_i = VEC[v].base; cfg_size_i = VEC[v].size; cfg_en_i = VEC[v].en;
            nxt();
            wr_accept_i = 1; wr_accept_addr_i = VEC[v].wa;
            nxt();
            wr_accept_i = 0;
            rd_req_i = 1; rd_addr_i = VEC[v].ra;
            #1 chk(vtag(v), rd_stall_o, VEC[v].stall);
            chk("R11 grant vs stall", rd_grant_o, !VEC[v].stall);
            nxt();
            wr_issue_i = 1;
            #1 chk("R7 write-first", rd_stall_o, VEC[v].stall);
            nxt();
            wr_issue_i = 0;
            #1 chk("R7 release", rd_stall_o, 1'b0);
            rd_req_i = 0;
            nxt();
        end

        cfg_base_i = 16'h0010; cfg_size_i = 16'h0000; cfg_en_i = 1;
        nxt();

        // R10: two in-window writes, stall until both are gone
        wr_accept_i = 1; wr_accept_addr_i = 22'h000400; nxt();
        wr_accept_addr_i = 22'h000420; nxt();
        wr_accept_i = 0; rd_req_i = 1; rd_addr_i = 22'h000430;
        #1 chk("R10 two pending", rd_stall_o, 1'b1);
        wr_issue_i = 1; nxt();
        #1 chk("R10 one left", rd_stall_o, 1'b1);
        nxt();
        wr_issue_i = 0;
        #1 chk("R10 both issued", rd_stall_o, 1'b0);

        // R10: outside write older than inside write
        wr_accept_i = 1; wr_accept_addr_i = 22'h000500; nxt();
        wr_accept_addr_i = 22'h000400; nxt();
        wr_accept_i = 0; rd_addr_i = 22'h000400;
        #1 chk("R10 order stall", rd_stall_o, 1'b1);
        wr_issue_i = 1; nxt();
        wr_issue_i = 0;
        #1 chk("R10 inside still queued", rd_stall_o, 1'b1);
        wr_issue_i = 1; nxt();
        wr_issue_i = 0;
        #1 chk("R10 queue drained", rd_stall_o, 1'b0);

        // R8: inside write older than outside write
        wr_accept_i = 1; wr_accept_addr_i = 22'h000400; nxt();
        wr_accept_addr_i = 22'h000500; nxt();
        wr_accept_i = 0; wr_issue_i = 1;
        #1 chk("R8 inside at head", rd_stall_o, 1'b1);
        nxt();
        wr_issue_i = 0;
        #1 chk("R8 only outside left", rd_stall_o, 1'b0);
        wr_issue_i = 1; nxt();
        wr_issue_i = 0;

        // R10: accept and issue in one cycle
        wr_accept_i = 1; wr_accept_addr_i = 22'h000500; nxt();
        wr_accept_addr_i = 22'h000400; wr_issue_i = 1;
        #1 chk("R10 accept+issue same cycle", rd_stall_o, 1'b0);
        nxt();
        wr_accept_i = 0; wr_issue_i = 0;
        #1 chk("R10 new entry kept", rd_stall_o, 1'b1);

        // R11: no request means no stall and no grant
        rd_req_i = 0;
        #1 chk("R11 idle stall", rd_stall_o, 1'b0);
        chk("R11 idle grant", rd_grant_o, 1'b0);
        rd_req_i = 1;

        // R9: enable change takes effect one cycle later
        cfg_en_i = 0;
        #1 chk("R9 old enable holds", rd_stall_o, 1'b1);
        nxt();
        #1 chk("R9 disabled", rd_stall_o, 1'b0);
        cfg_en_i = 1;
        #1 chk("R9 still disabled", rd_stall_o, 1'b0);
        nxt();
        #1 chk("R9 re-enabled", rd_stall_o, 1'b1);
        cfg_base_i = 16'h0100;
        #1 chk("R9 old window holds", rd_stall_o, 1'b1);
        nxt();
        #1 chk("R9 window moved", rd_stall_o, 1'b0);
        rd_req_i = 0;
        cfg_base_i = 16'h0010;
        wr_issue_i = 1; nxt();
        wr_issue_i = 0;

        // R1: reset in flight drops pending writes
        wr_accept_i = 1; wr_accept_addr_i = 22'h000400; nxt();
        wr_accept_i = 0; rst = 1; nxt(); nxt();
        rst = 0; rd_req_i = 1; rd_addr_i = 22'h000400;
        #1 chk("R1 reset off", rd_stall_o, 1'b0);
        nxt();
        #1 chk("R1 tracker cleared", rd_stall_o, 1'b0);
        rd_req_i = 0;
        nxt();

        done = 1;
        summary();
        $finish;
    end

endmodule